// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster for a parallel pixel output. A horizontal counter steps once per pixel clock and a vertical counter steps once per line. From their positions the block derives horizontal sync, vertical sync, a data-enable strobe and the x/y coordinates of the visible pixel. Software sets the geometry through a simple write port. There is one word for each of the following: horizontal timing, vertical timing, visible size, output polarity, and control.

Each line runs through the visible pixels, then the front porch, then the sync pulse, then the back porch. Each frame follows the same sequence, counted in lines. The geometry and polarity words are copied into a working set only at a frame boundary, so a write made while the raster runs leaves the current frame intact. The control word starts and stops the raster. It also carries a code for the number of data lines on the panel bus, which the block passes on both as the raw code and as a decoded count. Two outputs report which pixel-clock edge drives the data and which edge drives the syncs.

Top module: `raster_timing_gen`

## Requirements
- R1: Writes select a word by `wr_addr`: 0 control, 1 horizontal timing, 2 vertical timing, 3 visible size, 4 polarity. A write to addresses 5, 6 or 7 changes no output and no stored word.
- R2: In the horizontal word, the sync width minus one sits in bits 7:0, the front porch minus one in bits 19:8 and the back porch minus one in bits 31:20. A line lasts visible + front + sync + back clocks. hsync is active for the sync-width clocks that start right after the front porch.
- R3: In the vertical word, the sync width minus one sits in bits 7:0. The front porch is held as a plain line count in bits 19:8, and the back porch is held the same way in bits 31:20, so a value of zero is a zero-length porch. vsync is active on the sync lines that follow the visible lines and the front porch.
- R4: The visible width minus one sits in size bits 11:0 and the visible height minus one in bits 27:16. Data-enable is active only when both counters are inside the visible area. While it is active, `pix_x` and `pix_y` give the pixel position. At all other times both coordinates read 0.
- R5: Control bit 0 runs the raster. After the clock edge that stores a 1 there, one more edge passes, and then the outputs present pixel (0,0).
- R6: After the clock edge that clears control bit 0, one more pixel is presented and then all outputs go to their inactive levels with both coordinates at 0. A later enable restarts the raster at pixel (0,0).
- R7: Polarity bit 12 inverts vsync, bit 13 inverts hsync and bit 15 inverts data-enable. An inverted output idles high.
- R8: With polarity bit 18 set, vsync changes state in the column where hsync becomes active. With bit 18 clear, vsync changes state in column 0.
- R9: The timing, size and polarity words are applied only at a frame boundary. A write made during a frame takes effect from pixel (0,0) of the next frame. While the raster is stopped, the working set follows the written words.
- R10: Control bits 10:8 appear on `lines_code`. `lines_num` decodes them as 0→12, 1→16, 2→18, 3→24, 4→30, 5→36, and codes 6 and 7 give 24.
- R11: `data_fall` equals polarity bit 14. `sync_fall` equals polarity bit 14 when bit 17 is clear, and equals the inverse of bit 16 when bit 17 is set.
- R12: Synchronous active-low reset clears every word. The raster stops, the syncs and data-enable read 0, the coordinates read 0, and `lines_num` reads 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write value |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data-enable, polarity applied |
| pix_x | output | 12 | Visible pixel column, 0 outside the visible area |
| pix_y | output | 12 | Visible pixel row, 0 outside the visible area |
| lines_code | output | 3 | Data-line code from the control word |
| lines_num | output | 6 | Decoded data-line count |
| data_fall | output | 1 | Data driven on the falling pixel-clock edge |
| sync_fall | output | 1 | Syncs driven on the falling pixel-clock edge |

## Verification
The hardest case to reach from the ports is a geometry or polarity write that arrives in the middle of a running frame. The visible effect has to appear exactly at the next frame boundary and not one pixel earlier. The stimulus writes new words about twenty pixels into a frame, well away from the wrap. It then follows two complete frames, comparing every pixel against a model whose working set switches only when its own counters wrap. Aligned vsync, combined with a zero front porch, puts the vsync edge in the middle of a line next to the frame wrap, and this case is driven over two full frames as well.

// File: rtl/rtg_pkg.sv
// Package: shared constants for the raster timing generator.
// Holds the word addresses, the field positions the counters decode,
// and the data-line code decoder. Assumes 32-bit register words.
package rtg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_HTIM = 3'd1,
        SEL_VTIM = 3'd2,
        SEL_SIZE = 3'd3,
        SEL_POL  = 3'd4
    } word_sel_e;

    // Field positions inside the timing and size words
    localparam int SYNC_LSB  = 0;
    localparam int FRONT_LSB = 8;
    localparam int BACK_LSB  = 20;
    localparam int WID_LSB   = 0;
    localparam int HGT_LSB   = 16;

    // Polarity word bits (stored as a 7-bit slice starting at POL_LSB)
    localparam int POL_LSB       = 12;
    localparam int POL_INV_V     = 12;
    localparam int POL_INV_H     = 13;
    localparam int POL_DATA_FALL = 14;
    localparam int POL_INV_DE    = 15;
    localparam int POL_SYNC_RISE = 16;
    localparam int POL_SYNC_OWN  = 17;
    localparam int POL_ALIGN     = 18;
    localparam int POL_W         = POL_ALIGN - POL_LSB + 1;

    // Control word bits
    localparam int CTRL_RUN      = 0;
    localparam int CTRL_CODE_LSB = 8;
    localparam int CODE_W        = 3;

    // Decode the data-line code into a line count; unknown codes give 24.
    function automatic logic [5:0] lines_from_code(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return 6'd12;
            3'd1:    return 6'd16;
            3'd2:    return 6'd18;
            3'd3:    return 6'd24;
            3'd4:    return 6'd30;
            3'd5:    return 6'd36;
            default: return 6'd24;
        endcase
    endfunction

endpackage

// File: rtl/rtg_regs.sv
// Module: rtg_regs
// Stores the written words and a working copy of the geometry and
// polarity. The working copy reloads every cycle while stopped and
// only on the last pixel of a frame while running.
// Assumes wr_data is 32 bits wide and that field widths fit it.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int FW = 12,
    parameter int SW = 8,
    parameter int DW = 32,
    localparam int CW = FW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              frame_end,
    output logic              run,
    output logic [CODE_W-1:0] lines_code,
    output logic [5:0]        lines_num,
    output logic              data_fall,
    output logic              sync_fall,
    output logic [CW-1:0]     h_act,
    output logic [CW-1:0]     h_fp,
    output logic [CW-1:0]     h_sw,
    output logic [CW-1:0]     h_bp,
    output logic [CW-1:0]     v_act,
    output logic [CW-1:0]     v_fp,
    output logic [CW-1:0]     v_sw,
    output logic [CW-1:0]     v_bp,
    output logic              inv_hs,
    output logic              inv_vs,
    output logic              inv_de,
    output logic              align
);

    logic                run_q;
    logic [CODE_W-1:0]   code_q;
    logic [DW-1:0]       htim_q, vtim_q;
    logic [2*FW-1:0]     size_q;
    logic [POL_W-1:0]    pol_q;

    logic [DW-1:0]       sh_htim, sh_vtim;
    logic [2*FW-1:0]     sh_size;
    logic                sh_inv_h, sh_inv_v, sh_inv_de, sh_align;
    logic                load;

    // Capture software writes into the programmed words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            code_q <= '0;
            htim_q <= '0;
            vtim_q <= '0;
            size_q <= '0;
            pol_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                SEL_CTRL: begin
                    run_q  <= wr_data[CTRL_RUN];
                    code_q <= wr_data[CTRL_CODE_LSB +: CODE_W];
                end
                SEL_HTIM: htim_q <= wr_data;
                SEL_VTIM: vtim_q <= wr_data;
                SEL_SIZE: size_q <= {wr_data[HGT_LSB +: FW], wr_data[WID_LSB +: FW]};
                SEL_POL:  pol_q  <= wr_data[POL_LSB +: POL_W];
                default: ;
            endcase
        end
    end

    assign load = !run_q || frame_end;

    // Reload the working set when stopped or at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_htim   <= '0;
            sh_vtim   <= '0;
            sh_size   <= '0;
            sh_inv_h  <= 1'b0;
            sh_inv_v  <= 1'b0;
            sh_inv_de <= 1'b0;
            sh_align  <= 1'b0;
        end else if (load) begin
            sh_htim   <= htim_q;
            sh_vtim   <= vtim_q;
            sh_size   <= size_q;
            sh_inv_h  <= pol_q[POL_INV_H - POL_LSB];
            sh_inv_v  <= pol_q[POL_INV_V - POL_LSB];
            sh_inv_de <= pol_q[POL_INV_DE - POL_LSB];
            sh_align  <= pol_q[POL_ALIGN - POL_LSB];
        end
    end

    // Decode stored fields into counts: minus-one fields gain one, raw ones do not
    always_comb begin
        h_act = CW'(sh_size[FW-1:0]) + CW'(1);
        v_act = CW'(sh_size[2*FW-1:FW]) + CW'(1);
        h_sw  = CW'(sh_htim[SYNC_LSB +: SW]) + CW'(1);
        h_fp  = CW'(sh_htim[FRONT_LSB +: FW]) + CW'(1);
        h_bp  = CW'(sh_htim[BACK_LSB +: FW]) + CW'(1);
        v_sw  = CW'(sh_vtim[SYNC_LSB +: SW]) + CW'(1);
        v_fp  = CW'(sh_vtim[FRONT_LSB +: FW]);
        v_bp  = CW'(sh_vtim[BACK_LSB +: FW]);
    end

    // Expose control and clock-edge selections straight from the programmed words
    always_comb begin
        run        = run_q;
        lines_code = code_q;
        lines_num  = lines_from_code(code_q);
        data_fall  = pol_q[POL_DATA_FALL - POL_LSB];
        sync_fall  = pol_q[POL_SYNC_OWN - POL_LSB] ? !pol_q[POL_SYNC_RISE - POL_LSB]
                                                   : pol_q[POL_DATA_FALL - POL_LSB];
        inv_hs     = sh_inv_h;
        inv_vs     = sh_inv_v;
        inv_de     = sh_inv_de;
        align      = sh_align;
    end

    // R9: the working set never moves mid-frame
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_end) |=> ($stable(sh_htim) && $stable(sh_vtim) &&
                                 $stable(sh_size) && $stable(sh_inv_h)))
        else $error("working set changed inside a frame");

endmodule

// File: rtl/rtg_counters.sv
// Module: rtg_counters
// Pixel and line counters. Both are held at zero while stopped. The
// pixel counter wraps at h_total and the line counter wraps at v_total.
// Assumes both totals are at least 1 and constant within a frame.
module rtg_counters #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    output logic [CW-1:0] h,
    output logic [CW-1:0] v,
    output logic          frame_end
);

    logic line_end;

    assign line_end  = (h == h_total - CW'(1));
    assign frame_end = run && line_end && (v == v_total - CW'(1));

    // Advance pixel and line positions
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            h <= '0;
            v <= '0;
        end else if (line_end) begin
            h <= '0;
            v <= (v == v_total - CW'(1)) ? '0 : v + CW'(1);
        end else begin
            h <= h + CW'(1);
        end
    end

    // R2: the pixel counter stays inside the line
    p_h_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (h < h_total))
        else $error("pixel counter beyond line length");

    // R2: the last pixel of a line returns to column 0
    p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && line_end) |=> (h == '0))
        else $error("line did not wrap");

    // R3: the line counter stays inside the frame
    p_v_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (v < v_total))
        else $error("line counter beyond frame length");

endmodule

// File: rtl/rtg_outgen.sv
// Module: rtg_outgen
// Decodes the counter positions into sync, data-enable and coordinates,
// applies polarity and registers the result. With align set, vsync
// follows the previous line until the hsync column is reached.
// Assumes v_total is at least 1.
module rtg_outgen #(
    parameter int FW = 12,
    localparam int CW = FW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] h,
    input  logic [CW-1:0] v,
    input  logic [CW-1:0] h_act,
    input  logic [CW-1:0] h_fp,
    input  logic [CW-1:0] h_sw,
    input  logic [CW-1:0] v_act,
    input  logic [CW-1:0] v_fp,
    input  logic [CW-1:0] v_sw,
    input  logic [CW-1:0] v_total,
    input  logic          inv_hs,
    input  logic          inv_vs,
    input  logic          inv_de,
    input  logic          align,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [FW-1:0] x_o,
    output logic [FW-1:0] y_o
);

    logic [CW-1:0] hs_start, hs_stop, vs_start, vs_stop, v_prev;
    logic          hs_now, vs_now, vs_prev, de_now, vs_pick;

    // Region decode for the current position
    always_comb begin
        hs_start = h_act + h_fp;
        hs_stop  = hs_start + h_sw;
        vs_start = v_act + v_fp;
        vs_stop  = vs_start + v_sw;
        v_prev   = (v == '0) ? v_total - CW'(1) : v - CW'(1);
        hs_now   = (h >= hs_start) && (h < hs_stop);
        vs_now   = (v >= vs_start) && (v < vs_stop);
        vs_prev  = (v_prev >= vs_start) && (v_prev < vs_stop);
        de_now   = (h < h_act) && (v < v_act);
        vs_pick  = (align && (h < hs_start)) ? vs_prev : vs_now;
    end

    // Register outputs with polarity, inactive while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            de_o    <= 1'b0;
            x_o     <= '0;
            y_o     <= '0;
        end else if (!run) begin
            hsync_o <= inv_hs;
            vsync_o <= inv_vs;
            de_o    <= inv_de;
            x_o     <= '0;
            y_o     <= '0;
        end else begin
            hsync_o <= hs_now ^ inv_hs;
            vsync_o <= vs_pick ^ inv_vs;
            de_o    <= de_now ^ inv_de;
            x_o     <= de_now ? h[FW-1:0] : '0;
            y_o     <= de_now ? v[FW-1:0] : '0;
        end
    end

    // R6: a stopped raster presents inactive levels next cycle
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (x_o == '0 && y_o == '0 && de_o == $past(inv_de) &&
                  hsync_o == $past(inv_hs) && vsync_o == $past(inv_vs)))
        else $error("outputs active while stopped");

    // R4: coordinates are zero whenever data-enable is inactive
    p_coord_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o == $past(inv_de)) |-> (x_o == '0 && y_o == '0))
        else $error("coordinates nonzero outside visible area");

endmodule

// File: rtl/raster_timing_gen.sv
// Module: raster_timing_gen
// Top of the raster timing generator: register words, counters and
// output stage. All outputs are in the pixel clock domain.
// Assumes a single clock and a synchronous active-low reset.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int FW = 12,
    parameter int SW = 8,
    parameter int DW = 32,
    localparam int CW = FW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [FW-1:0]     pix_x,
    output logic [FW-1:0]     pix_y,
    output logic [CODE_W-1:0] lines_code,
    output logic [5:0]        lines_num,
    output logic              data_fall,
    output logic              sync_fall
);

    logic          run, frame_end;
    logic [CW-1:0] h_act, h_fp, h_sw, h_bp, v_act, v_fp, v_sw, v_bp;
    logic [CW-1:0] h_total, v_total, h, v;
    logic          inv_hs, inv_vs, inv_de, align;

    // Line and frame lengths from the working set
    always_comb begin
        h_total = h_act + h_fp + h_sw + h_bp;
        v_total = v_act + v_fp + v_sw + v_bp;
    end

    rtg_regs #(.FW(FW), .SW(SW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .run(run),
        .lines_code(lines_code), .lines_num(lines_num),
        .data_fall(data_fall), .sync_fall(sync_fall),
        .h_act(h_act), .h_fp(h_fp), .h_sw(h_sw), .h_bp(h_bp),
        .v_act(v_act), .v_fp(v_fp), .v_sw(v_sw), .v_bp(v_bp),
        .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_de(inv_de), .align(align)
    );

    rtg_counters #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .h_total(h_total),
        .v_total(v_total), .h(h), .v(v), .frame_end(frame_end)
    );

    rtg_outgen #(.FW(FW)) u_out (
        .clk(clk), .rst_n(rst_n), .run(run), .h(h), .v(v),
        .h_act(h_act), .h_fp(h_fp), .h_sw(h_sw),
        .v_act(v_act), .v_fp(v_fp), .v_sw(v_sw), .v_total(v_total),
        .inv_hs(inv_hs), .inv_vs(inv_vs), .inv_de(inv_de), .align(align),
        .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .x_o(pix_x), .y_o(pix_y)
    );

    // R10: decoded line count always matches a legal value
    p_lines_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lines_num == 6'd12 || lines_num == 6'd16 || lines_num == 6'd18 ||
         lines_num == 6'd24 || lines_num == 6'd30 || lines_num == 6'd36))
        else $error("illegal line count");

endmodule

// File: tb/raster_timing_gen_test.sv
// Bench: directed scenarios with a pixel-accurate model of the raster.
module raster_timing_gen_test;

    localparam int FW = 12;
    localparam logic [2:0] A_CTRL = 3'd0, A_HTIM = 3'd1, A_VTIM = 3'd2,
                           A_SIZE = 3'd3, A_POL = 3'd4;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, data_fall, sync_fall;
    logic [FW-1:0] pix_x, pix_y;
    logic [2:0]  lines_code;
    logic [5:0]  lines_num;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Programmed (p_), shadow-model (s_) and applied (a_) copies
    logic [31:0] p_ctrl = '0, p_htim = '0, p_vtim = '0, p_size = '0, p_pol = '0;
    logic [31:0] s_htim = '0, s_vtim = '0, s_size = '0, s_pol = '0;
    logic [31:0] a_htim = '0, a_vtim = '0, a_size = '0, a_pol = '0;
    bit running = 1'b0;
    int bh = 0, bv = 0;

    always #4 clk = ~clk;

    raster_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .lines_code(lines_code),
        .lines_num(lines_num), .data_fall(data_fall), .sync_fall(sync_fall)
    );

    function automatic logic [31:0] mk_h(input int sw, input int fp, input int bp);
        return 32'(sw - 1) | (32'(fp - 1) << 8) | (32'(bp - 1) << 20);
    endfunction
    function automatic logic [31:0] mk_v(input int sw, input int fp, input int bp);
        return 32'(sw - 1) | (32'(fp) << 8) | (32'(bp) << 20);
    endfunction
    function automatic logic [31:0] mk_size(input int w, input int ht);
        return 32'(w - 1) | (32'(ht - 1) << 16);
    endfunction

    function automatic int line_len();
        return int'(a_size[11:0]) + 1 + int'(a_htim[19:8]) + 1 +
               int'(a_htim[7:0]) + 1 + int'(a_htim[31:20]) + 1;
    endfunction
    function automatic int frame_lines();
        return int'(a_size[27:16]) + 1 + int'(a_vtim[19:8]) +
               int'(a_vtim[7:0]) + 1 + int'(a_vtim[31:20]);
    endfunction

    // Expected raster outputs (before polarity) at a position
    task automatic model(input int h, input int v, output bit ehs, output bit evs,
                         output bit ede, output int ex, output int ey);
        int ha, hs0, hw, va, vs0, vw, pv;
        bit vnow, vprev;
        ha  = int'(a_size[11:0]) + 1;
        hs0 = ha + int'(a_htim[19:8]) + 1;
        hw  = int'(a_htim[7:0]) + 1;
        va  = int'(a_size[27:16]) + 1;
        vs0 = va + int'(a_vtim[19:8]);
        vw  = int'(a_vtim[7:0]) + 1;
        pv  = (v == 0) ? frame_lines() - 1 : v - 1;
        vnow  = (v >= vs0) && (v < vs0 + vw);
        vprev = (pv >= vs0) && (pv < vs0 + vw);
        ehs = (h >= hs0) && (h < hs0 + hw);
        evs = (a_pol[18] && h < hs0) ? vprev : vnow;
        ede = (h < ha) && (v < va);
        ex  = ede ? h : 0;
        ey  = ede ? v : 0;
    endtask

    task automatic check_out(input string tag, input bit ehs, input bit evs,
                             input bit ede, input int ex, input int ey);
        n_chk++;
        if (hsync !== ehs || vsync !== evs || de !== ede ||
            pix_x !== FW'(ex) || pix_y !== FW'(ey)) begin
            n_bad++;
            $display("FAIL %s at h=%0d v=%0d: got hs=%0b vs=%0b de=%0b x=%0d y=%0d, expected hs=%0b vs=%0b de=%0b x=%0d y=%0d",
                     tag, bh, bv, hsync, vsync, de, pix_x, pix_y, ehs, evs, ede, ex, ey);
        end
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
        end
    endtask

    task automatic poke(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        case (a)
            A_CTRL: p_ctrl = d;
            A_HTIM: p_htim = d;
            A_VTIM: p_vtim = d;
            A_SIZE: p_size = d;
            A_POL:  p_pol  = d;
            default: ;
        endcase
    endtask

    // Advance n clocks, checking every output against the model
    task automatic step(input int n, input string tag);
        bit ehs, evs, ede;
        int ex, ey;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (running) begin
                model(bh, bv, ehs, evs, ede, ex, ey);
                check_out(tag, ehs ^ a_pol[13], evs ^ a_pol[12], ede ^ a_pol[15], ex, ey);
                if (bh == line_len() - 1) begin
                    bh = 0;
                    if (bv == frame_lines() - 1) begin
                        bv = 0;
                        a_htim = p_htim; a_vtim = p_vtim; a_size = p_size; a_pol = p_pol;
                    end else bv++;
                end else bh++;
            end else begin
                check_out(tag, a_pol[13], a_pol[12], a_pol[15], 0, 0);
                a_htim = s_htim; a_vtim = s_vtim; a_size = s_size; a_pol = s_pol;
                s_htim = p_htim; s_vtim = p_vtim; s_size = p_size; s_pol = p_pol;
            end
        end
    endtask

    task automatic start_raster(input string tag);
        poke(A_CTRL, p_ctrl | 32'h1);
        step(1, tag);
        running = 1'b1; bh = 0; bv = 0;
        a_htim = p_htim; a_vtim = p_vtim; a_size = p_size; a_pol = p_pol;
    endtask

    task automatic stop_raster(input string tag);
        poke(A_CTRL, p_ctrl & ~32'h1);
        step(1, tag);
        running = 1'b0;
        s_htim = p_htim; s_vtim = p_vtim; s_size = p_size; s_pol = p_pol;
    endtask

    task automatic t_reset();
        check_out("R12 reset", 1'b0, 1'b0, 1'b0, 0, 0);
        check_val("R12 lines_num", int'(lines_num), 12);
        check_val("R12 lines_code", int'(lines_code), 0);
        check_val("R12 sync_fall", int'(sync_fall), 0);
        step(2, "R12 idle");
    endtask

    task automatic t_basic();
        poke(A_HTIM, mk_h(3, 2, 2)); step(1, "R2 setup");
        poke(A_VTIM, mk_v(2, 1, 1)); step(1, "R3 setup");
        poke(A_SIZE, mk_size(8, 4)); step(1, "R4 setup");
        start_raster("R5 start");
        step(1, "R5 first pixel");
        step(2 * 15 * 8, "R2 R3 R4 raster");
    endtask

    task automatic t_vraw();
        stop_raster("R6 stop");
        poke(A_VTIM, mk_v(1, 0, 2)); step(2, "R3 setup");
        start_raster("R5 start");
        step(2 * 15 * 7, "R3 raw porches");
    endtask

    task automatic t_polarity();
        stop_raster("R6 stop");
        poke(A_POL, (32'h1 << 12) | (32'h1 << 13) | (32'h1 << 15));
        step(3, "R7 idle levels");
        start_raster("R7 start");
        step(15 * 7, "R7 inverted raster");
    endtask

    task automatic t_align();
        stop_raster("R6 stop");
        poke(A_POL, 32'h1 << 18); step(1, "R8 setup");
        poke(A_VTIM, mk_v(2, 0, 1)); step(2, "R8 setup");
        start_raster("R8 start");
        step(2 * 15 * 7, "R8 aligned vsync");
    endtask

    task automatic t_shadow();
        step(20, "R9 before");
        poke(A_HTIM, mk_h(1, 3, 4)); step(1, "R9 mid-frame");
        poke(A_POL, (32'h1 << 13)); step(1, "R9 mid-frame");
        poke(A_SIZE, mk_size(6, 3)); step(1, "R9 mid-frame");
        step(2 * 15 * 7, "R9 after");
    endtask

    task automatic t_disable();
        step(7, "R6 before");
        stop_raster("R6 stop");
        step(5, "R6 idle");
        start_raster("R6 restart");
        step(14 * 6, "R6 restarted raster");
    endtask

    task automatic t_bad_addr();
        logic [2:0] code_before;
        code_before = lines_code;
        for (int a = 5; a < 8; a++) begin
            poke(3'(a), 32'hFFFF_FFFF);
            step(1, "R1 ignored write");
        end
        check_val("R1 lines_code kept", int'(lines_code), int'(code_before));
        check_val("R1 sync_fall kept", int'(sync_fall), 0);
        step(14 * 6, "R1 raster unaffected");
    endtask

    task automatic t_lines();
        int exp_num[8] = '{12, 16, 18, 24, 30, 36, 24, 24};
        for (int c = 0; c < 8; c++) begin
            poke(A_CTRL, (p_ctrl & 32'hFFFF_F8FF) | (32'(c) << 8));
            step(1, "R10 code write");
            check_val("R10 lines_code", int'(lines_code), c);
            check_val("R10 lines_num", int'(lines_num), exp_num[c]);
        end
    endtask

    task automatic t_edges();
        for (int k = 0; k < 8; k++) begin
            bit b14, b16, b17;
            b14 = k[0]; b16 = k[1]; b17 = k[2];
            poke(A_POL, (p_pol & ~32'h0003_4000) | (32'(b14) << 14) |
                        (32'(b16) << 16) | (32'(b17) << 17));
            step(1, "R11 pol write");
            check_val("R11 data_fall", int'(data_fall), int'(b14));
            check_val("R11 sync_fall", int'(sync_fall), b17 ? int'(!b16) : int'(b14));
        end
        step(3, "R11 idle");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_vraw();
        t_polarity();
        t_align();
        t_shadow();
        t_disable();
        t_bad_addr();
        t_lines();
        stop_raster("R6 stop");
        step(3, "R6 idle");
        t_edges();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

endmodule